// File: doc/BRIEF.md
# Smart card character and block timing supervisor

This block watches the timing of an asynchronous smart card link and reports violations in elementary time units. A card UART feeds it an ETU tick, a strobe on each detected start bit and a strobe when a character completes. The block also sees the link direction, a last-transmit-byte marker, the card reset level and the supply-good level. All intervals are measured between the leading edges of successive characters. The block raises one sticky flag per kind of violation. Each flag stays set until a write-one-to-clear pulse or the loss of supply.

After the card reset line rises, the block enters an answer-to-reset phase. In that phase it bounds the wait for the first character and the length of the whole answer. The phase ends after a programmed number of characters, and protocol operation follows. In operation it applies either character-protocol rules (a guard time and a work waiting limit) or block-protocol rules (a character waiting limit inside a block, a block waiting limit for the card's reply, and a 5-bit block guard time when the direction turns around). When the terminal is about to send, the block does not report guard violations. Instead it raises a hold towards the UART until the minimum spacing has passed.

Top module: `scTimingSupervisor`

## Requirements
- R1: While supplyOk is low, every flag reads 0 and txHold is 0. This holds on the same cycle for txHold and from the next clock edge for the flags.
- R2: Flags are sticky. Bit order: 0 guard, 1 work wait, 2 character wait, 3 block wait, 4 initial wait, 5 answer timeout. A 1 on clrFlags bit i clears flag i at the next edge, but a violation detected in the same cycle leaves it set.
- R3: After a rising edge of cardRst, if the first start bit has not arrived when the number of ETU ticks since that edge reaches iwtLimit, flag bit 4 is set on that tick.
- R4: In the answer phase, flag bit 5 is set on the tick where the number of ticks since the cardRst rising edge reaches atrLimit. The phase ends, and protocol operation begins, when the atrLen-th character completes.
- R5: With protoT1 = 0 in operation and receive direction, flag bit 1 is set on the tick where the ticks since the last start bit reach bwtLimit. The same limit applies between answer characters.
- R6: With protoT1 = 1 in receive direction, the gap since the last start bit is checked against cwtLimit (flag bit 2) if the previous character was received, and against bwtLimit (flag bit 3) if it was transmitted.
- R7: A received start bit in operation sets flag bit 0 when the ticks since the previous start bit are at most egtLimit. With protoT1 = 1 and a transmitted previous character, bgtLimit is used instead. A gap one above the limit passes.
- R8: In transmit direction, txHold is 1 while the ticks since the previous start bit are at most the guard limit: bgtLimit if protoT1 = 1 and the previous character was received, otherwise egtLimit.
- R9: A character completing in transmit direction with lastTxByte = 1 switches the block to receive timing from the next cycle, without any change of dirRx.
- R10: A start bit arriving in the same cycle as the tick that would reach a waiting limit restarts the gap and sets no waiting flag.
- R11: A change of the dirRx level (1 = receive) selects the new direction from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| supplyOk | input | 1 | Card supply good level |
| cardRst | input | 1 | Card reset line level (1 = released) |
| etuTick | input | 1 | One-cycle pulse per elementary time unit |
| startBit | input | 1 | Start bit detected strobe |
| charDone | input | 1 | Character complete strobe |
| dirRx | input | 1 | Direction level, 1 = receive, 0 = transmit |
| lastTxByte | input | 1 | Current transmitted character is the last of its block |
| protoT1 | input | 1 | 0 = character protocol, 1 = block protocol |
| egtLimit | input | 8 | Extra guard time in ETUs |
| bgtLimit | input | 5 | Block guard time in ETUs |
| cwtLimit | input | 16 | Character waiting limit |
| bwtLimit | input | 16 | Block / work waiting limit |
| iwtLimit | input | 16 | Initial waiting limit after reset release |
| atrLimit | input | 16 | Whole answer-to-reset limit |
| atrLen | input | 8 | Number of answer characters expected |
| clrFlags | input | 6 | Write-one-to-clear pulses, one per flag |
| txHold | output | 1 | Hold request to the UART transmitter |
| flags | output | 6 | Sticky violation flags |

## Verification
Two pairs of events can fall in one cycle. The first pair is a start bit and the tick that would expire a waiting limit. The second is a clear pulse and a new violation of the same flag. The bench aligns a start-bit strobe with the expiring tick and expects no flag and a restarted gap. It then repeats the expiring tick with the clear bit raised and expects the flag to stay set. A behavioural model computes flags and hold every cycle, and the sequence also crosses from the answer phase into operation and turns the direction around through the last-byte marker.

// File: rtl/scTimingPkg.sv
package scTimingPkg;
  localparam int FLAG_N  = 6;
  localparam int F_GUARD = 0;
  localparam int F_WWT   = 1;
  localparam int F_CWT   = 2;
  localparam int F_BWT   = 3;
  localparam int F_IWT   = 4;
  localparam int F_ATR   = 5;

  typedef struct packed {
    logic gapClr;
    logic gapInc;
    logic atrClr;
    logic atrInc;
    logic chrClr;
    logic chrInc;
  } dpCtl_t;

  typedef struct packed {
    logic leEgt;
    logic leBgt;
    logic hitBwt;
    logic hitCwt;
    logic hitIwt;
    logic hitAtr;
    logic hitLen;
  } dpSts_t;
endpackage

// File: rtl/scSatCount.sv
module scSatCount #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] cnt
);
  localparam logic [W-1:0] CNT_MAX = '1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                       cnt <= '0;
    else if (clr)                    cnt <= '0;
    else if (inc && cnt != CNT_MAX)  cnt <= cnt + 1'b1;
  end

  // saturation keeps the measured interval from wrapping (R3)
  assert_sat_hold_R3: assert property (@(posedge clk) disable iff (!rstN)
    (cnt == CNT_MAX && !clr) |=> cnt == CNT_MAX);
endmodule

// File: rtl/scTimingDp.sv
module scTimingDp
  import scTimingPkg::*;
#(
  parameter int GAP_W = 16,
  parameter int EGT_W = 8,
  parameter int BGT_W = 5,
  parameter int LEN_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpCtl_t           ctl,
  input  logic [EGT_W-1:0] egtLimit,
  input  logic [BGT_W-1:0] bgtLimit,
  input  logic [GAP_W-1:0] cwtLimit,
  input  logic [GAP_W-1:0] bwtLimit,
  input  logic [GAP_W-1:0] iwtLimit,
  input  logic [GAP_W-1:0] atrLimit,
  input  logic [LEN_W-1:0] atrLen,
  output dpSts_t           sts
);
  logic [GAP_W-1:0] gapCnt;
  logic [GAP_W-1:0] atrCnt;
  logic [LEN_W-1:0] chrCnt;
  logic [GAP_W:0]   gapNext;
  logic [GAP_W:0]   atrNext;
  logic [LEN_W:0]   chrNext;

  scSatCount #(.W(GAP_W)) gapCnt_i (
    .clk(clk), .rstN(rstN), .clr(ctl.gapClr), .inc(ctl.gapInc), .cnt(gapCnt));
  scSatCount #(.W(GAP_W)) atrCnt_i (
    .clk(clk), .rstN(rstN), .clr(ctl.atrClr), .inc(ctl.atrInc), .cnt(atrCnt));
  scSatCount #(.W(LEN_W)) chrCnt_i (
    .clk(clk), .rstN(rstN), .clr(ctl.chrClr), .inc(ctl.chrInc), .cnt(chrCnt));

  always_comb begin
    gapNext    = {1'b0, gapCnt} + 1'b1;
    atrNext    = {1'b0, atrCnt} + 1'b1;
    chrNext    = {1'b0, chrCnt} + 1'b1;
    sts.leEgt  = gapCnt <= {{(GAP_W-EGT_W){1'b0}}, egtLimit};
    sts.leBgt  = gapCnt <= {{(GAP_W-BGT_W){1'b0}}, bgtLimit};
    sts.hitBwt = gapNext == {1'b0, bwtLimit};
    sts.hitCwt = gapNext == {1'b0, cwtLimit};
    sts.hitIwt = gapNext == {1'b0, iwtLimit};
    sts.hitAtr = atrNext == {1'b0, atrLimit};
    sts.hitLen = chrNext == {1'b0, atrLen};
  end
endmodule

// File: rtl/scTimingCtrl.sv
module scTimingCtrl
  import scTimingPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              supplyOk,
  input  logic              cardRst,
  input  logic              etuTick,
  input  logic              startBit,
  input  logic              charDone,
  input  logic              dirRx,
  input  logic              lastTxByte,
  input  logic              protoT1,
  input  logic [FLAG_N-1:0] clrFlags,
  input  dpSts_t            sts,
  output dpCtl_t            ctl,
  output logic              txHold,
  output logic [FLAG_N-1:0] flags
);
  logic rstQ, dirQ, rxMode, atrPh, operPh, hasPrev, prevRx;
  logic rise, live, curRx, waitOn, tickWait;
  logic [FLAG_N-1:0] setVec;

  always_comb begin
    rise     = cardRst && !rstQ;
    live     = supplyOk && cardRst && !rise;
    curRx    = atrPh || rxMode;
    waitOn   = atrPh || (operPh && rxMode);
    tickWait = live && etuTick && !startBit && waitOn;

    ctl.gapClr = !live || startBit;
    ctl.gapInc = etuTick;
    ctl.atrClr = !live;
    ctl.atrInc = etuTick && atrPh;
    ctl.chrClr = !live;
    ctl.chrInc = charDone && atrPh;

    setVec = '0;
    setVec[F_GUARD] = live && startBit && operPh && rxMode && hasPrev &&
                      ((protoT1 && !prevRx) ? sts.leBgt : sts.leEgt);
    if (atrPh) begin
      setVec[F_IWT] = tickWait && !hasPrev && sts.hitIwt;
      setVec[F_WWT] = tickWait && hasPrev && sts.hitBwt;
    end else if (!protoT1) begin
      setVec[F_WWT] = tickWait && sts.hitBwt;
    end else begin
      setVec[F_CWT] = tickWait && prevRx && sts.hitCwt;
      setVec[F_BWT] = tickWait && !prevRx && sts.hitBwt;
    end
    setVec[F_ATR] = live && etuTick && atrPh && sts.hitAtr;

    txHold = supplyOk && cardRst && operPh && !rxMode && hasPrev &&
             ((protoT1 && prevRx) ? sts.leBgt : sts.leEgt);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rstQ <= 1'b0; dirQ <= 1'b0; rxMode <= 1'b0;
      atrPh <= 1'b0; operPh <= 1'b0; hasPrev <= 1'b0; prevRx <= 1'b0;
    end else if (!supplyOk) begin
      rstQ <= 1'b0; dirQ <= dirRx; rxMode <= dirRx;
      atrPh <= 1'b0; operPh <= 1'b0; hasPrev <= 1'b0; prevRx <= 1'b0;
    end else begin
      rstQ <= cardRst;
      dirQ <= dirRx;
      if (dirRx != dirQ)                         rxMode <= dirRx;
      else if (charDone && lastTxByte && !rxMode) rxMode <= 1'b1;
      if (!cardRst || rise) begin
        atrPh   <= rise;
        operPh  <= 1'b0;
        hasPrev <= 1'b0;
        prevRx  <= 1'b0;
      end else begin
        if (startBit) begin
          hasPrev <= 1'b1;
          prevRx  <= curRx;
        end
        if (charDone && atrPh && sts.hitLen) begin
          atrPh  <= 1'b0;
          operPh <= 1'b1;
        end
      end
    end
  end

  for (genvar i = 0; i < FLAG_N; i++) begin : gFlag
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)          flags[i] <= 1'b0;
      else if (!supplyOk) flags[i] <= 1'b0;
      else                flags[i] <= (flags[i] && !clrFlags[i]) || setVec[i];
    end
  end

  assert_vcc_clear_R1: assert property (@(posedge clk) disable iff (!rstN)
    !supplyOk |=> flags == '0);

  assert_sticky_R2: assert property (@(posedge clk) disable iff (!rstN)
    supplyOk |=> ((flags & $past(flags & ~clrFlags)) == $past(flags & ~clrFlags)));

  assert_phase_excl_R4: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({atrPh, operPh}));

  assert_last_tx_R9: assert property (@(posedge clk) disable iff (!rstN)
    (supplyOk && charDone && lastTxByte && !rxMode && dirRx == dirQ) |=> rxMode);
endmodule

// File: rtl/scTimingSupervisor.sv
module scTimingSupervisor
  import scTimingPkg::*;
#(
  parameter int GAP_W = 16,
  parameter int EGT_W = 8,
  parameter int BGT_W = 5,
  parameter int LEN_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              supplyOk,
  input  logic              cardRst,
  input  logic              etuTick,
  input  logic              startBit,
  input  logic              charDone,
  input  logic              dirRx,
  input  logic              lastTxByte,
  input  logic              protoT1,
  input  logic [EGT_W-1:0]  egtLimit,
  input  logic [BGT_W-1:0]  bgtLimit,
  input  logic [GAP_W-1:0]  cwtLimit,
  input  logic [GAP_W-1:0]  bwtLimit,
  input  logic [GAP_W-1:0]  iwtLimit,
  input  logic [GAP_W-1:0]  atrLimit,
  input  logic [LEN_W-1:0]  atrLen,
  input  logic [FLAG_N-1:0] clrFlags,
  output logic              txHold,
  output logic [FLAG_N-1:0] flags
);
  dpCtl_t ctl;
  dpSts_t sts;

  scTimingCtrl ctrl_i (
    .clk(clk), .rstN(rstN), .supplyOk(supplyOk), .cardRst(cardRst),
    .etuTick(etuTick), .startBit(startBit), .charDone(charDone),
    .dirRx(dirRx), .lastTxByte(lastTxByte), .protoT1(protoT1),
    .clrFlags(clrFlags), .sts(sts), .ctl(ctl), .txHold(txHold), .flags(flags));

  scTimingDp #(.GAP_W(GAP_W), .EGT_W(EGT_W), .BGT_W(BGT_W), .LEN_W(LEN_W)) dp_i (
    .clk(clk), .rstN(rstN), .ctl(ctl), .egtLimit(egtLimit), .bgtLimit(bgtLimit),
    .cwtLimit(cwtLimit), .bwtLimit(bwtLimit), .iwtLimit(iwtLimit),
    .atrLimit(atrLimit), .atrLen(atrLen), .sts(sts));
endmodule

// File: tb/scTimingSupervisor_tb_top.sv
module scTimingSupervisor_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic supplyOk = 1'b0, cardRst = 1'b0, etuTick = 1'b0, startBit = 1'b0;
  logic charDone = 1'b0, dirRx = 1'b1, lastTxByte = 1'b0, protoT1 = 1'b0;
  logic [7:0]  egtLimit = 8'd6;
  logic [4:0]  bgtLimit = 5'd3;
  logic [15:0] cwtLimit = 16'd4, bwtLimit = 16'd10, iwtLimit = 16'd5, atrLimit = 16'd12;
  logic [7:0]  atrLen = 8'd2;
  logic [5:0]  clrFlags = 6'd0;
  logic        txHold;
  logic [5:0]  flags;

  int total = 0, bad = 0;

  scTimingSupervisor dut_i (
    .clk(clk), .rstN(rstN), .supplyOk(supplyOk), .cardRst(cardRst),
    .etuTick(etuTick), .startBit(startBit), .charDone(charDone), .dirRx(dirRx),
    .lastTxByte(lastTxByte), .protoT1(protoT1), .egtLimit(egtLimit),
    .bgtLimit(bgtLimit), .cwtLimit(cwtLimit), .bwtLimit(bwtLimit),
    .iwtLimit(iwtLimit), .atrLimit(atrLimit), .atrLen(atrLen),
    .clrFlags(clrFlags), .txHold(txHold), .flags(flags));

  always #5 clk = ~clk;

  // behavioural reference
  int  mGap = 0, mAtr = 0, mChars = 0;
  bit  mAtrPh = 0, mOper = 0, mRx = 0, mDirQ = 0, mPrevRx = 0, mHasPrev = 0, mRstQ = 0;
  bit [5:0] mFlags = 0;

  function automatic bit modelHold();
    int lim;
    lim = (protoT1 && mPrevRx) ? int'(bgtLimit) : int'(egtLimit);
    return supplyOk && cardRst && mOper && !mRx && mHasPrev && (mGap <= lim);
  endfunction

  always @(posedge clk) begin
    bit rise, live, curRx, endAtr;
    bit [5:0] setV;
    int lim;
    if (rstN) begin
      if (!supplyOk) begin
        mGap = 0; mAtr = 0; mChars = 0; mAtrPh = 0; mOper = 0; mHasPrev = 0;
        mPrevRx = 0; mRstQ = 0; mRx = dirRx; mDirQ = dirRx; mFlags = 0;
      end else begin
        rise = cardRst && !mRstQ;
        live = cardRst && !rise;
        curRx = mAtrPh || mRx;
        setV = 0;
        if (live) begin
          if (startBit && mOper && mRx && mHasPrev) begin
            lim = (protoT1 && !mPrevRx) ? int'(bgtLimit) : int'(egtLimit);
            if (mGap <= lim) setV[0] = 1;
          end
          if (etuTick && !startBit && (mAtrPh || (mOper && mRx))) begin
            if (mAtrPh) begin
              if (!mHasPrev) begin if (mGap + 1 == int'(iwtLimit)) setV[4] = 1; end
              else if (mGap + 1 == int'(bwtLimit)) setV[1] = 1;
            end else if (!protoT1) begin
              if (mGap + 1 == int'(bwtLimit)) setV[1] = 1;
            end else if (mPrevRx) begin
              if (mGap + 1 == int'(cwtLimit)) setV[2] = 1;
            end else if (mGap + 1 == int'(bwtLimit)) setV[3] = 1;
          end
          if (etuTick && mAtrPh && mAtr + 1 == int'(atrLimit)) setV[5] = 1;
        end
        mFlags = (mFlags & ~clrFlags) | setV;
        if (dirRx != mDirQ) mRx = dirRx;
        else if (charDone && lastTxByte && !mRx) mRx = 1;
        mDirQ = dirRx;
        endAtr = charDone && mAtrPh && (mChars + 1 == int'(atrLen));
        if (!live) begin
          mGap = 0; mAtr = 0; mChars = 0;
        end else begin
          if (startBit) mGap = 0;
          else if (etuTick && mGap < 65535) mGap++;
          if (etuTick && mAtrPh && mAtr < 65535) mAtr++;
          if (charDone && mAtrPh) mChars++;
        end
        if (!cardRst || rise) begin
          mAtrPh = rise; mOper = 0; mHasPrev = 0; mPrevRx = 0;
        end else begin
          if (startBit) begin mHasPrev = 1; mPrevRx = curRx; end
          if (endAtr) begin mAtrPh = 0; mOper = 1; end
        end
        mRstQ = cardRst;
      end
    end
    #2;
    if (rstN) begin
      total++;
      if (flags !== mFlags) begin
        bad++;
        $display("FAIL R2 model flags act=%b exp=%b t=%0t", flags, mFlags, $time);
      end
      total++;
      if (txHold !== modelHold()) begin
        bad++;
        $display("FAIL R8 model txHold act=%b exp=%b t=%0t", txHold, modelHold(), $time);
      end
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic step(input bit t, input bit s, input bit d, input logic [5:0] c);
    @(negedge clk);
    etuTick = t; startBit = s; charDone = d; clrFlags = c;
  endtask

  task automatic idle();
    step(0, 0, 0, 6'd0);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      step(1, 0, 0, 6'd0);
      idle();
    end
  endtask

  initial begin
    #2_000_000;
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    idle();
    check("R1 reset flags", flags, 0);
    check("R1 reset hold", txHold, 0);
    supplyOk = 1'b1; idle();
    cardRst = 1'b1; idle();
    ticks(4);
    check("R3 iwt not yet", flags[4], 0);
    ticks(1);
    check("R3 iwt expiry", flags[4], 1);
    ticks(6);
    check("R4 atr not yet", flags[5], 0);
    ticks(1);
    check("R4 atr expiry", flags, 6'b110000);
    step(0, 0, 0, 6'h3f); idle();
    check("R2 w1c clear", flags, 0);
    // second answer, completes normally
    iwtLimit = 16'd50; atrLimit = 16'd200;
    cardRst = 1'b0; idle();
    cardRst = 1'b1; idle();
    ticks(2);
    step(0, 1, 0, 0); step(0, 0, 1, 0); idle();
    ticks(3);
    step(0, 1, 0, 0); step(0, 0, 1, 0); idle();
    check("R4 answer ends clean", flags, 0);
    // character protocol waiting
    ticks(9);
    check("R5 wwt not yet", flags[1], 0);
    ticks(1);
    check("R5 wwt expiry", flags, 6'b000010);
    step(0, 0, 0, 6'h3f); idle();
    // guard on receive
    step(0, 1, 0, 0); idle();
    ticks(2);
    step(0, 1, 0, 0); idle();
    check("R7 guard violation", flags, 6'b000001);
    step(0, 0, 0, 6'h3f); idle();
    ticks(7);
    step(0, 1, 0, 0); idle();
    check("R7 gap above limit passes", flags[0], 0);
    // block protocol, character waiting
    protoT1 = 1'b1; idle();
    ticks(3);
    check("R6 cwt not yet", flags[2], 0);
    ticks(1);
    check("R6 cwt expiry", flags, 6'b000100);
    step(0, 0, 0, 6'h3f); idle();
    // turn to transmit
    dirRx = 1'b0; idle(); idle();
    check("R11 tx selected, gap above bgt", txHold, 0);
    step(0, 1, 0, 0); idle();
    check("R8 hold after tx start", txHold, 1);
    ticks(6);
    check("R8 hold at egt", txHold, 1);
    ticks(1);
    check("R8 hold released", txHold, 0);
    lastTxByte = 1'b1;
    step(0, 0, 1, 0);
    idle();
    lastTxByte = 1'b0;
    check("R9 receive after last byte", txHold, 0);
    ticks(2);
    check("R9 bwt not yet", flags[3], 0);
    ticks(1);
    check("R9 bwt reply expiry", flags, 6'b001000);
    step(0, 0, 0, 6'h3f); idle();
    // coincidence of start and expiring tick
    egtLimit = 8'd2;
    step(0, 1, 0, 0); idle();
    ticks(3);
    step(1, 1, 0, 0); idle();
    check("R10 start wins over expiry", flags, 0);
    ticks(3);
    step(1, 0, 0, 6'b000100); idle();
    check("R2 set wins over clear", flags[2], 1);
    supplyOk = 1'b0; idle();
    check("R1 supply loss hold", txHold, 0);
    idle();
    check("R1 supply loss flags", flags, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule